// File: doc/BRIEF.md
# Polled Keyboard, Serial and Timer I/O Hub

This block is a polled peripheral on the system clock. The clock is derived elsewhere by dividing a 20 MHz oscillator by four, which gives 5 MHz. The processor reaches every function through a small I/O address window. It reads a register with `ioRd` and writes one with `ioWr`. The read value on `ioRdata` follows `ioAddr` combinationally.

The block contains four functions:
- a receiver for PS/2 keyboard frames;
- an oversampled asynchronous serial receiver with a one-byte holding register;
- an independent asynchronous serial transmitter;
- a free-running tick counter.

A single status register gathers the ready and idle flags and the three navigation switches. A generic 8-bit output latch drives LEDs and a speaker line. There are no interrupts. Software polls the status register and then reads the data ports. Reading a data port clears its ready flag.

Address map: 0 keyboard data (read), 1 serial receive data (read), 2 serial transmit data (write), 3 status (read), 4 tick count (read), 5 output latch (write, read back).

Top module: `pollIoHub`

## Requirements
- R1: After reset, the following values hold:
  - status reads 0x04 with the switches low (only the transmitter-idle flag is set);
  - the tick count reads 0;
  - the output latch reads 0;
  - `txOut` is high.
- R2: The PS/2 receiver samples `ps2Data` on each falling edge of the synchronized `ps2Clk`. A frame is 11 bits: start 0, eight data bits least significant first, odd parity, stop 1. When a frame is valid, its byte appears on port 0 and status bit 0 sets.
- R3: A PS/2 frame with a wrong parity, start or stop bit is discarded. Status bit 0 stays clear and port 0 keeps its previous byte.
- R4: The keyboard path has no buffer. A second valid frame that arrives before port 0 is read replaces the first byte.
- R5: Reading port 0 clears status bit 0. Reading port 1 clears status bit 1.
- R6: The serial receiver takes 8N1 frames, least significant bit first, at BIT_CLKS (87) system clocks per bit. It samples mid-bit. On a valid stop bit the byte is placed on port 1 and status bit 1 sets.
- R7: The received byte stays readable on port 1 while the next frame is shifted in. It is replaced only when that frame's stop bit is accepted.
- R8: A low pulse on `rxIn` that is high again at the middle of the start bit is rejected. No byte is produced, and the next proper frame is received correctly.
- R9: A write to port 2 while the transmitter is idle sends one frame on `txOut`, least significant bit first. The frame is a 0 start bit, 8 data bits and a 1 stop bit, each BIT_CLKS clocks long. Status bit 2 is clear during the frame and set again after it.
- R10: A write to port 2 while the transmitter is busy is ignored. The frame in flight is unchanged.
- R11: The tick count on port 4 increments once every TICK_DIV (16) system clocks and wraps modulo 256.
- R12: Status bits 3, 4 and 5 reflect the `swUp`, `swDown` and `swSet` inputs. Bits 7 and 6 read 0.
- R13: A write to port 5 loads the output latch. The latch drives `outPort` and reads back on port 5.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Synchronous active-low reset |
| ioAddr | input | 3 | I/O port address |
| ioRd | input | 1 | Read strobe (clears ready flags on data ports) |
| ioWr | input | 1 | Write strobe |
| ioWdata | input | 8 | Write data |
| ioRdata | output | 8 | Read data for the addressed port |
| ps2Clk | input | 1 | PS/2 clock line |
| ps2Data | input | 1 | PS/2 data line |
| rxIn | input | 1 | Serial receive line |
| txOut | output | 1 | Serial transmit line |
| swUp | input | 1 | Navigation switch up |
| swDown | input | 1 | Navigation switch down |
| swSet | input | 1 | Navigation switch set |
| outPort | output | 8 | Output latch (LEDs and speaker) |

## Verification
Register reads are combinational, so port values are sampled in the same cycle that the address is applied. A clearing read takes effect at the next edge. A transmit write loads the start bit at the edge that samples the strobe. The bench therefore samples `txOut` 43 clocks after that edge and then every 87 clocks, which lands mid-bit for all ten bits. The idle flag is checked after the tenth bit period has elapsed. Received serial bytes are loaded about 45 clocks into the stop bit, after two synchronizer stages. Keyboard bytes are loaded three clocks after the last falling edge. The bench polls only after these points, and it peeks at the old byte well before the stop bit of a following frame. Tick checks compare two reads 160 and 4096 clocks apart, which must differ by exactly 10 and 0 whatever the phase of the prescaler.

// File: rtl/pollIoPkg.sv
package pollIoPkg;
  localparam logic [2:0] ADDR_KBD  = 3'd0;
  localparam logic [2:0] ADDR_RX   = 3'd1;
  localparam logic [2:0] ADDR_TX   = 3'd2;
  localparam logic [2:0] ADDR_STAT = 3'd3;
  localparam logic [2:0] ADDR_TICK = 3'd4;
  localparam logic [2:0] ADDR_OUT  = 3'd5;

  typedef struct packed {
    logic kbdShift;
    logic kbdLoad;
    logic kbdClr;
    logic rxShift;
    logic rxLoad;
    logic rxClr;
    logic txLoad;
    logic txShift;
    logic tickInc;
    logic outLoad;
  } ioStrobe_t;

  typedef enum logic [1:0] {RX_IDLE, RX_START, RX_DATA, RX_STOP} rxState_t;
endpackage

// File: rtl/pollIoCtl.sv
module pollIoCtl
  import pollIoPkg::*;
#(
  parameter int BIT_CLKS = 87,
  parameter int TICK_DIV = 16
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic [2:0] ioAddr,
  input  logic       ioRd,
  input  logic       ioWr,
  input  logic       ps2Clk,
  input  logic       ps2Data,
  input  logic       rxIn,
  input  logic       kbdFrameOk,
  output logic       kbdBit,
  output logic       rxBit,
  output logic       txIdle,
  output ioStrobe_t  st
);
  localparam int CNT_W  = $clog2(BIT_CLKS);
  localparam int HALF   = BIT_CLKS / 2;
  localparam int TICK_W = $clog2(TICK_DIV);
  localparam logic [CNT_W-1:0] BIT_END  = CNT_W'(BIT_CLKS - 1);
  localparam logic [CNT_W-1:0] HALF_END = CNT_W'(HALF - 1);

  logic [1:0] ps2ClkS, ps2DatS, rxS;
  logic       ps2ClkPrev, ps2Fall;
  logic [3:0] kbdCnt;
  rxState_t   rxState;
  logic [CNT_W-1:0] rxCnt, txCnt;
  logic [2:0] rxIdx;
  logic       txBusy;
  logic [3:0] txIdx;
  logic [TICK_W-1:0] tickPre;

  assign kbdBit  = ps2DatS[1];
  assign rxBit   = rxS[1];
  assign ps2Fall = ps2ClkPrev & ~ps2ClkS[1];
  assign txIdle  = ~txBusy;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      ps2ClkS <= 2'b11; ps2DatS <= 2'b11; rxS <= 2'b11; ps2ClkPrev <= 1'b1;
    end else begin
      ps2ClkS <= {ps2ClkS[0], ps2Clk};
      ps2DatS <= {ps2DatS[0], ps2Data};
      rxS <= {rxS[0], rxIn};
      ps2ClkPrev <= ps2ClkS[1];
    end
  end

  // keyboard frame counter
  always_ff @(posedge clk) begin
    if (!rstN) kbdCnt <= '0;
    else if (ps2Fall) kbdCnt <= (kbdCnt == 4'd10) ? 4'd0 : kbdCnt + 4'd1;
  end

  // serial receiver sequencing
  always_ff @(posedge clk) begin
    if (!rstN) begin
      rxState <= RX_IDLE; rxCnt <= '0; rxIdx <= '0;
    end else begin
      unique case (rxState)
        RX_IDLE: if (!rxBit) begin rxState <= RX_START; rxCnt <= '0; end
        RX_START:
          if (rxCnt == HALF_END) begin
            rxCnt <= '0; rxIdx <= '0;
            rxState <= rxBit ? RX_IDLE : RX_DATA;
          end else rxCnt <= rxCnt + 1'b1;
        RX_DATA:
          if (rxCnt == BIT_END) begin
            rxCnt <= '0; rxIdx <= rxIdx + 3'd1;
            if (rxIdx == 3'd7) rxState <= RX_STOP;
          end else rxCnt <= rxCnt + 1'b1;
        RX_STOP:
          if (rxCnt == BIT_END) begin rxCnt <= '0; rxState <= RX_IDLE; end
          else rxCnt <= rxCnt + 1'b1;
        default: rxState <= RX_IDLE;
      endcase
    end
  end

  // transmitter sequencing and tick prescaler
  always_ff @(posedge clk) begin
    if (!rstN) begin
      txBusy <= 1'b0; txCnt <= '0; txIdx <= '0; tickPre <= '0;
    end else begin
      tickPre <= (tickPre == TICK_W'(TICK_DIV - 1)) ? '0 : tickPre + 1'b1;
      if (st.txLoad) begin
        txBusy <= 1'b1; txCnt <= '0; txIdx <= '0;
      end else if (txBusy) begin
        if (txCnt == BIT_END) begin
          txCnt <= '0; txIdx <= txIdx + 4'd1;
          if (txIdx == 4'd9) txBusy <= 1'b0;
        end else txCnt <= txCnt + 1'b1;
      end
    end
  end

  always_comb begin
    st = '0;
    st.kbdShift = ps2Fall && (kbdCnt != 4'd10);
    st.kbdLoad  = ps2Fall && (kbdCnt == 4'd10) && kbdFrameOk && kbdBit;
    st.kbdClr   = ioRd && (ioAddr == ADDR_KBD);
    st.rxShift  = (rxState == RX_DATA) && (rxCnt == BIT_END);
    st.rxLoad   = (rxState == RX_STOP) && (rxCnt == BIT_END) && rxBit;
    st.rxClr    = ioRd && (ioAddr == ADDR_RX);
    st.txLoad   = ioWr && (ioAddr == ADDR_TX) && !txBusy;
    st.txShift  = txBusy && (txCnt == BIT_END);
    st.tickInc  = (tickPre == TICK_W'(TICK_DIV - 1));
    st.outLoad  = ioWr && (ioAddr == ADDR_OUT);
  end

  // R8
  start_reject_chk: assert property (@(posedge clk) disable iff (!rstN)
    (rxState == RX_START && rxCnt == HALF_END && rxBit) |=> rxState == RX_IDLE);
  // R10
  tx_no_restart_chk: assert property (@(posedge clk) disable iff (!rstN)
    (txBusy && txCnt != BIT_END) |=> (txCnt == $past(txCnt) + 1'b1));
endmodule

// File: rtl/pollIoDp.sv
module pollIoDp
  import pollIoPkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  ioStrobe_t  st,
  input  logic       kbdBit,
  input  logic       rxBit,
  input  logic       txIdle,
  input  logic [2:0] ioAddr,
  input  logic [7:0] ioWdata,
  input  logic [2:0] swIn,
  output logic       kbdFrameOk,
  output logic [7:0] ioRdata,
  output logic       txOut,
  output logic [7:0] outPort
);
  logic [9:0] kbdSh, txSh;
  logic [7:0] kbdData, rxSh, rxData, tickCnt, outLatch;
  logic       kbdReady, rxReady;

  assign kbdFrameOk = !kbdSh[0] && (^kbdSh[9:1]);
  assign txOut   = txSh[0];
  assign outPort = outLatch;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      kbdSh <= '0; kbdData <= '0; kbdReady <= 1'b0;
      rxSh <= '0; rxData <= '0; rxReady <= 1'b0;
      txSh <= '1; tickCnt <= '0; outLatch <= '0;
    end else begin
      if (st.kbdShift) kbdSh <= {kbdBit, kbdSh[9:1]};
      if (st.kbdLoad) begin kbdData <= kbdSh[8:1]; kbdReady <= 1'b1; end
      else if (st.kbdClr) kbdReady <= 1'b0;
      if (st.rxShift) rxSh <= {rxBit, rxSh[7:1]};
      if (st.rxLoad) begin rxData <= rxSh; rxReady <= 1'b1; end
      else if (st.rxClr) rxReady <= 1'b0;
      if (st.txLoad) txSh <= {1'b1, ioWdata, 1'b0};
      else if (st.txShift) txSh <= {1'b1, txSh[9:1]};
      if (st.tickInc) tickCnt <= tickCnt + 8'd1;
      if (st.outLoad) outLatch <= ioWdata;
    end
  end

  always_comb begin
    unique case (ioAddr)
      ADDR_KBD:  ioRdata = kbdData;
      ADDR_RX:   ioRdata = rxData;
      ADDR_STAT: ioRdata = {2'b00, swIn, txIdle, rxReady, kbdReady};
      ADDR_TICK: ioRdata = tickCnt;
      ADDR_OUT:  ioRdata = outLatch;
      default:   ioRdata = 8'h00;
    endcase
  end

  // R9
  tx_idle_high_chk: assert property (@(posedge clk) disable iff (!rstN)
    txIdle |-> txOut);
  // R5
  read_clears_chk: assert property (@(posedge clk) disable iff (!rstN)
    (st.kbdClr && !st.kbdLoad) |=> !kbdReady);
  // R11
  tick_step_chk: assert property (@(posedge clk) disable iff (!rstN)
    st.tickInc |=> tickCnt == 8'($past(tickCnt) + 8'd1));
  // R2
  kbd_valid_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(kbdReady) |-> $past(kbdFrameOk));
endmodule

// File: rtl/pollIoHub.sv
module pollIoHub
  import pollIoPkg::*;
#(
  parameter int BIT_CLKS = 87,
  parameter int TICK_DIV = 16
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic [2:0] ioAddr,
  input  logic       ioRd,
  input  logic       ioWr,
  input  logic [7:0] ioWdata,
  output logic [7:0] ioRdata,
  input  logic       ps2Clk,
  input  logic       ps2Data,
  input  logic       rxIn,
  output logic       txOut,
  input  logic       swUp,
  input  logic       swDown,
  input  logic       swSet,
  output logic [7:0] outPort
);
  ioStrobe_t st;
  logic kbdBit, rxBit, txIdle, kbdFrameOk;

  pollIoCtl #(.BIT_CLKS(BIT_CLKS), .TICK_DIV(TICK_DIV)) uCtl (
    .clk(clk), .rstN(rstN), .ioAddr(ioAddr), .ioRd(ioRd), .ioWr(ioWr),
    .ps2Clk(ps2Clk), .ps2Data(ps2Data), .rxIn(rxIn), .kbdFrameOk(kbdFrameOk),
    .kbdBit(kbdBit), .rxBit(rxBit), .txIdle(txIdle), .st(st));

  pollIoDp uDp (
    .clk(clk), .rstN(rstN), .st(st), .kbdBit(kbdBit), .rxBit(rxBit),
    .txIdle(txIdle), .ioAddr(ioAddr), .ioWdata(ioWdata),
    .swIn({swSet, swDown, swUp}), .kbdFrameOk(kbdFrameOk),
    .ioRdata(ioRdata), .txOut(txOut), .outPort(outPort));
endmodule

// File: tb/sim_pollIoHub.sv
module sim_pollIoHub;
  logic clk = 1'b0, rstN = 1'b0;
  logic [2:0] ioAddr = '0;
  logic ioRd = 1'b0, ioWr = 1'b0;
  logic [7:0] ioWdata = '0, ioRdata, outPort;
  logic ps2Clk = 1'b1, ps2Data = 1'b1, rxIn = 1'b1, txOut;
  logic swUp = 1'b0, swDown = 1'b0, swSet = 1'b0;
  int nRun = 0, nFail = 0;
  bit finished = 1'b0;

  always #5 clk = ~clk;

  pollIoHub u0 (.clk(clk), .rstN(rstN), .ioAddr(ioAddr), .ioRd(ioRd), .ioWr(ioWr),
    .ioWdata(ioWdata), .ioRdata(ioRdata), .ps2Clk(ps2Clk), .ps2Data(ps2Data),
    .rxIn(rxIn), .txOut(txOut), .swUp(swUp), .swDown(swDown), .swSet(swSet),
    .outPort(outPort));

  task automatic chk(string req, logic [7:0] act, logic [7:0] exp);
    nRun++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s actual=%02h expected=%02h", req, act, exp);
    end
  endtask

  task automatic waitClk(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic peek(logic [2:0] a, output logic [7:0] v);
    ioAddr = a; #1; v = ioRdata;
  endtask

  task automatic readPort(logic [2:0] a, output logic [7:0] v);
    @(negedge clk); ioAddr = a; #1; v = ioRdata; ioRd = 1'b1;
    @(negedge clk); ioRd = 1'b0;
  endtask

  task automatic writePort(logic [2:0] a, logic [7:0] d);
    @(negedge clk); ioAddr = a; ioWdata = d; ioWr = 1'b1;
    @(negedge clk); ioWr = 1'b0;
  endtask

  task automatic ps2Send(logic [7:0] d, bit badPar);
    logic [10:0] fr;
    fr = {1'b1, (~^d) ^ badPar, d, 1'b0};
    for (int i = 0; i < 11; i++) begin
      ps2Data = fr[i]; waitClk(10); ps2Clk = 1'b0; waitClk(10); ps2Clk = 1'b1;
    end
    ps2Data = 1'b1; waitClk(10);
  endtask

  task automatic serSend(logic [7:0] d);
    logic [9:0] fr;
    fr = {1'b1, d, 1'b0};
    for (int i = 0; i < 10; i++) begin rxIn = fr[i]; waitClk(87); end
    waitClk(20);
  endtask

  task automatic testReset;
    logic [7:0] v;
    peek(3'd3, v); chk("R1 status", v, 8'h04);
    peek(3'd4, v); chk("R1 tick", v, 8'h00);
    peek(3'd5, v); chk("R1 latch", v, 8'h00);
    chk("R1 txOut", {7'd0, txOut}, 8'h01);
  endtask

  task automatic testKeyboard;
    logic [7:0] v;
    ps2Send(8'hA5, 1'b0);
    peek(3'd3, v); chk("R2 kbd ready", v & 8'h01, 8'h01);
    readPort(3'd0, v); chk("R2 kbd data", v, 8'hA5);
    peek(3'd3, v); chk("R5 kbd ready cleared", v & 8'h01, 8'h00);
    ps2Send(8'h3C, 1'b1);
    peek(3'd3, v); chk("R3 bad parity no ready", v & 8'h01, 8'h00);
    peek(3'd0, v); chk("R3 data kept", v, 8'hA5);
    ps2Send(8'h11, 1'b0);
    ps2Send(8'h7E, 1'b0);
    readPort(3'd0, v); chk("R4 overwrite", v, 8'h7E);
  endtask

  task automatic testSerialRx;
    logic [7:0] v;
    logic [9:0] fr;
    serSend(8'h4B);
    peek(3'd3, v); chk("R6 rx ready", v & 8'h02, 8'h02);
    peek(3'd1, v); chk("R6 rx data", v, 8'h4B);
    fr = {1'b1, 8'hD2, 1'b0};
    for (int i = 0; i < 10; i++) begin
      rxIn = fr[i]; waitClk(87);
      if (i == 5) begin peek(3'd1, v); chk("R7 old byte held", v, 8'h4B); end
    end
    waitClk(20);
    readPort(3'd1, v); chk("R7 new byte", v, 8'hD2);
    peek(3'd3, v); chk("R5 rx ready cleared", v & 8'h02, 8'h00);
    rxIn = 1'b0; waitClk(15); rxIn = 1'b1; waitClk(300);
    peek(3'd3, v); chk("R8 glitch rejected", v & 8'h02, 8'h00);
    serSend(8'h81);
    readPort(3'd1, v); chk("R8 next frame ok", v, 8'h81);
  endtask

  task automatic testTx;
    logic [7:0] v;
    logic [9:0] fr;
    fr = {1'b1, 8'h96, 1'b0};
    writePort(3'd2, 8'h96);
    waitClk(43);
    for (int i = 0; i < 10; i++) begin
      chk($sformatf("R9 tx bit %0d", i), {7'd0, txOut}, {7'd0, fr[i]});
      if (i == 2) begin
        peek(3'd3, v); chk("R9 busy", v & 8'h04, 8'h00);
        writePort(3'd2, 8'h00); waitClk(85);
      end else if (i < 9) waitClk(87);
    end
    waitClk(50);
    peek(3'd3, v); chk("R9 idle after frame", v & 8'h04, 8'h04);
    chk("R10 line idle", {7'd0, txOut}, 8'h01);
  endtask

  task automatic testTick;
    logic [7:0] a, b;
    @(negedge clk); peek(3'd4, a); waitClk(160); peek(3'd4, b);
    chk("R11 tick step", b - a, 8'd10);
    waitClk(4096); peek(3'd4, a);
    chk("R11 tick wrap", a, b);
  endtask

  task automatic testMisc;
    logic [7:0] v;
    swUp = 1'b1; swDown = 1'b0; swSet = 1'b1; #1;
    peek(3'd3, v); chk("R12 switches", v & 8'hF8, 8'h28);
    swUp = 1'b0; swDown = 1'b1; swSet = 1'b0; #1;
    peek(3'd3, v); chk("R12 switches b", v & 8'hF8, 8'h10);
    writePort(3'd5, 8'hC3);
    peek(3'd5, v); chk("R13 latch readback", v, 8'hC3);
    chk("R13 outPort", outPort, 8'hC3);
  endtask

  initial begin
    waitClk(4); rstN = 1'b1;
    testReset();
    testKeyboard();
    testSerialRx();
    testTx();
    testTick();
    testMisc();
    finished = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", nRun, nFail);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      nRun++; nFail++;
      $display("FAIL watchdog actual=timeout expected=done");
      $display("  [TB] %0d tests run, %0d failed", nRun, nFail);
      $finish;
    end
  end
endmodule